// File: doc/BRIEF.md
# Logic analyzer host command decoder

This block sits behind a UART receiver in a logic analyzer and turns the host's byte stream into configuration and control. Each command starts with an opcode byte. Opcodes with bit 7 clear are one-byte commands that raise a one-cycle strobe (reset, run, identify, metadata request). Opcodes with bit 7 set are followed by four argument bytes, least significant byte first, and write a 32-bit word into the configuration register file.

The register file holds the sample clock divider, the packed capture read and delay counts, the flag word and, for each of four trigger stages, a mask, a value and a config word. Fields the sampling core needs are unpacked from these registers: channel-group enables, demux, noise filter and run-length encoding enables, the per-stage capture-start bit, and read and delay counts with the minus-one offset removed. Framing recovers by itself in two ways. A run of five 0x00 bytes always ends with the decoder back at the opcode stage. A long gap between bytes drops a partly received long command.

Top module: `la_cmd_decoder`

## Requirements
- R1: Opcode bytes 0x00, 0x01, 0x02 and 0x04 each raise exactly one of `pulse_reset`, `pulse_run`, `pulse_id` and `pulse_meta` (in that pairing) for one cycle, starting in the cycle after the byte is accepted. Any other opcode with bit 7 clear raises nothing.
- R2: An opcode with bit 7 set starts a long command. The next four accepted bytes are its argument, the first byte being bits 7:0 and the fourth bits 31:24. These bytes never raise a strobe.
- R3: Long opcode 0x80 loads `divider` with argument bits 23:0. The sample rate is the base clock divided by (divider + 1), doubled when demux is on.
- R4: Long opcode 0x81 sets `read_count` to argument bits 15:0 plus one and `delay_count` to bits 31:16 plus one. Both counts are 17 bits wide and in units of four samples.
- R5: Long opcode 0x82 loads `flags` with argument bits 15:0. `demux_en` is flag bit 0, `filter_en` is bit 1 and `rle_en` is bit 8. `group_en[g]` is the inverse of flag bit 2+g, so a set bit disables 8-bit channel group g.
- R6: Long opcode 0xC0 | (s<<2) | k writes trigger stage s: k=0 writes the mask, k=1 the value and k=2 the config. `trig_arm[s]` equals bit 3 of stage s config, which marks the stage that starts capture. Stage s occupies bits 32*s+31:32*s of each trigger bus.
- R7: A long opcode that is none of the above (including k=3) consumes its four argument bytes and changes no register.
- R8: A register changes only after the fourth argument byte has arrived, and every bit of the word changes in the same cycle. This happens two cycles after that byte is accepted.
- R9: Five consecutive 0x00 bytes leave the decoder expecting an opcode, from any position. Zero bytes that complete a pending long command are taken as argument bytes, and the remaining zeros act as reset opcodes.
- R10: If no byte arrives for GAP_CYCLES cycles while argument bytes are pending, the partial command is discarded and the next byte is an opcode.
- R11: After reset, all strobes are low, `divider`, `flags` and all trigger words are zero, both counts read 1, `group_en` is 4'hF and `trig_arm` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_byte | input | 8 | Received byte |
| in_vld | input | 1 | `in_byte` is valid this cycle |
| pulse_reset | output | 1 | Reset command strobe |
| pulse_run | output | 1 | Run command strobe |
| pulse_id | output | 1 | Identify request strobe |
| pulse_meta | output | 1 | Metadata request strobe |
| divider | output | 24 | Sample clock divider |
| read_count | output | 17 | Samples to read, in units of four |
| delay_count | output | 17 | Samples after trigger, in units of four |
| flags | output | 16 | Raw flag word |
| demux_en | output | 1 | Double-rate sampling enable |
| filter_en | output | 1 | Noise filter enable |
| rle_en | output | 1 | Run-length encoding enable |
| group_en | output | 4 | Channel group enables |
| trig_mask | output | 128 | Trigger masks, stage s in bits 32s+31:32s |
| trig_value | output | 128 | Trigger values, same packing |
| trig_cfg | output | 128 | Trigger config words, same packing |
| trig_arm | output | 4 | Capture-start bit of each stage |

## Verification
The decoder is driven with a table of long commands whose argument bytes are all distinct. This shows up a swapped byte order, a swapped half of the capture word, or a flag bit decoded at the wrong position. Trigger writes go to different stages and kinds, so a wrong stage or kind decode lands in a visibly wrong register. Short opcodes are sent alone, inside argument fields and as unused values, to separate real strobes from argument data. Zero runs from different positions inside a long command, and a long pause, exercise framing recovery. A check on the divider between the third and fourth argument bytes tells an atomic write apart from a piecewise one.

// File: rtl/la_cmd_pkg.sv
package la_cmd_pkg;
    localparam logic [7:0] OP_RESET = 8'h00;
    localparam logic [7:0] OP_RUN   = 8'h01;
    localparam logic [7:0] OP_ID    = 8'h02;
    localparam logic [7:0] OP_META  = 8'h04;
    localparam logic [7:0] OP_DIV   = 8'h80;
    localparam logic [7:0] OP_SIZE  = 8'h81;
    localparam logic [7:0] OP_FLAGS = 8'h82;

    localparam int ARG_W  = 32;
    localparam int HALF_W = 16;

    typedef enum logic {PH_IDLE, PH_ARGS} phase_t;

    typedef struct packed {
        logic rst;
        logic run;
        logic id;
        logic meta;
    } strobe_t;
endpackage

// File: rtl/la_cmd_framer.sv
module la_cmd_framer
    import la_cmd_pkg::*;
#(
    parameter int GAP_CYCLES = 1000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       in_byte,
    input  logic             in_vld,
    output strobe_t          stb,
    output logic             wr_vld,
    output logic [7:0]       wr_op,
    output logic [ARG_W-1:0] wr_arg
);
    localparam int GAP_W = $clog2(GAP_CYCLES);

    typedef struct packed {
        phase_t           phase;
        logic [7:0]       opc;
        logic [1:0]       cnt;
        logic [ARG_W-1:0] arg;
        logic [GAP_W-1:0] gap;
        strobe_t          stb;
        logic             wr_vld;
        logic [7:0]       wr_op;
        logic [ARG_W-1:0] wr_arg;
    } fr_t;

    fr_t fr_d, fr_q;

    always_comb begin
        fr_d        = fr_q;
        fr_d.stb    = '0;
        fr_d.wr_vld = 1'b0;
        case (fr_q.phase)
            PH_IDLE: begin
                fr_d.gap = '0;
                if (in_vld) begin
                    if (in_byte[7]) begin
                        fr_d.phase = PH_ARGS;
                        fr_d.opc   = in_byte;
                        fr_d.cnt   = 2'd0;
                    end else begin
                        case (in_byte)
                            OP_RESET: fr_d.stb.rst  = 1'b1;
                            OP_RUN:   fr_d.stb.run  = 1'b1;
                            OP_ID:    fr_d.stb.id   = 1'b1;
                            OP_META:  fr_d.stb.meta = 1'b1;
                            default:  ;
                        endcase
                    end
                end
            end
            default: begin
                if (in_vld) begin
                    fr_d.gap = '0;
                    fr_d.arg = {in_byte, fr_q.arg[ARG_W-1:8]};
                    if (fr_q.cnt == 2'd3) begin
                        fr_d.phase  = PH_IDLE;
                        fr_d.wr_vld = 1'b1;
                        fr_d.wr_op  = fr_q.opc;
                        fr_d.wr_arg = {in_byte, fr_q.arg[ARG_W-1:8]};
                    end else begin
                        fr_d.cnt = fr_q.cnt + 2'd1;
                    end
                end else if (32'(fr_q.gap) == GAP_CYCLES - 1) begin
                    fr_d.phase = PH_IDLE;
                    fr_d.gap   = '0;
                end else begin
                    fr_d.gap = fr_q.gap + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) fr_q <= '0;
        else     fr_q <= fr_d;
    end

    assign stb    = fr_q.stb;
    assign wr_vld = fr_q.wr_vld;
    assign wr_op  = fr_q.wr_op;
    assign wr_arg = fr_q.wr_arg;

    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(stb)); // R1
    AST_STROBE_NEEDS_BYTE: assert property (@(posedge clk) disable iff (rst)
        (stb != '0) |-> $past(in_vld)); // R1
    AST_ARGS_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        (fr_q.phase == PH_ARGS && in_vld) |=> (stb == '0)); // R2
    AST_GAP_BOUND: assert property (@(posedge clk) disable iff (rst)
        32'(fr_q.gap) < GAP_CYCLES); // R10
endmodule

// File: rtl/la_cmd_regs.sv
module la_cmd_regs
    import la_cmd_pkg::*;
#(
    parameter int NSTAGE = 4,
    parameter int DIV_W  = 24,
    parameter int FLAG_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_vld,
    input  logic [7:0]              wr_op,
    input  logic [ARG_W-1:0]        wr_arg,
    output logic [DIV_W-1:0]        divider,
    output logic [HALF_W:0]         read_count,
    output logic [HALF_W:0]         delay_count,
    output logic [FLAG_W-1:0]       flags,
    output logic [NSTAGE*ARG_W-1:0] trig_mask,
    output logic [NSTAGE*ARG_W-1:0] trig_value,
    output logic [NSTAGE*ARG_W-1:0] trig_cfg
);
    localparam int STG_W = (NSTAGE > 1) ? $clog2(NSTAGE) : 1;

    typedef struct packed {
        logic [DIV_W-1:0]              div;
        logic [HALF_W-1:0]             rd;
        logic [HALF_W-1:0]             dl;
        logic [FLAG_W-1:0]             flg;
        logic [NSTAGE-1:0][ARG_W-1:0]  msk;
        logic [NSTAGE-1:0][ARG_W-1:0]  val;
        logic [NSTAGE-1:0][ARG_W-1:0]  cfg;
    } rf_t;

    rf_t rf_d, rf_q;

    logic             stg_hit;
    logic [STG_W-1:0] stg_idx;

    always_comb begin
        stg_hit = (wr_op[7:6] == 2'b11) && (32'(wr_op[5:2]) < NSTAGE);
        stg_idx = wr_op[2 +: STG_W];
        rf_d    = rf_q;
        if (wr_vld) begin
            case (wr_op)
                OP_DIV:   rf_d.div = wr_arg[DIV_W-1:0];
                OP_SIZE: begin
                    rf_d.rd = wr_arg[HALF_W-1:0];
                    rf_d.dl = wr_arg[HALF_W +: HALF_W];
                end
                OP_FLAGS: rf_d.flg = wr_arg[FLAG_W-1:0];
                default: begin
                    if (stg_hit) begin
                        case (wr_op[1:0])
                            2'd0:    rf_d.msk[stg_idx] = wr_arg;
                            2'd1:    rf_d.val[stg_idx] = wr_arg;
                            2'd2:    rf_d.cfg[stg_idx] = wr_arg;
                            default: ;
                        endcase
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rf_q <= '0;
        else     rf_q <= rf_d;
    end

    assign divider     = rf_q.div;
    assign read_count  = {1'b0, rf_q.rd} + 1'b1;
    assign delay_count = {1'b0, rf_q.dl} + 1'b1;
    assign flags       = rf_q.flg;

    for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
        assign trig_mask [s*ARG_W +: ARG_W] = rf_q.msk[s];
        assign trig_value[s*ARG_W +: ARG_W] = rf_q.val[s];
        assign trig_cfg  [s*ARG_W +: ARG_W] = rf_q.cfg[s];
    end

    AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (rst)
        !wr_vld |=> $stable(rf_q)); // R8
    AST_UNKNOWN_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_vld && wr_op[7:6] == 2'b11 && wr_op[1:0] == 2'd3) |=> $stable(rf_q)); // R7
endmodule

// File: rtl/la_cmd_decoder.sv
module la_cmd_decoder
    import la_cmd_pkg::*;
#(
    parameter int NSTAGE     = 4,
    parameter int DIV_W      = 24,
    parameter int FLAG_W     = 16,
    parameter int NGROUP     = 4,
    parameter int GAP_CYCLES = 1000
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [7:0]              in_byte,
    input  logic                    in_vld,
    output logic                    pulse_reset,
    output logic                    pulse_run,
    output logic                    pulse_id,
    output logic                    pulse_meta,
    output logic [DIV_W-1:0]        divider,
    output logic [HALF_W:0]         read_count,
    output logic [HALF_W:0]         delay_count,
    output logic [FLAG_W-1:0]       flags,
    output logic                    demux_en,
    output logic                    filter_en,
    output logic                    rle_en,
    output logic [NGROUP-1:0]       group_en,
    output logic [NSTAGE*ARG_W-1:0] trig_mask,
    output logic [NSTAGE*ARG_W-1:0] trig_value,
    output logic [NSTAGE*ARG_W-1:0] trig_cfg,
    output logic [NSTAGE-1:0]       trig_arm
);
    localparam int GRP_LSB  = 2;
    localparam int RLE_BIT  = 8;
    localparam int ARM_BIT  = 3;

    strobe_t          stb;
    logic             wr_vld;
    logic [7:0]       wr_op;
    logic [ARG_W-1:0] wr_arg;

    la_cmd_framer #(.GAP_CYCLES(GAP_CYCLES)) u_framer (
        .clk    (clk),
        .rst    (rst),
        .in_byte(in_byte),
        .in_vld (in_vld),
        .stb    (stb),
        .wr_vld (wr_vld),
        .wr_op  (wr_op),
        .wr_arg (wr_arg)
    );

    la_cmd_regs #(.NSTAGE(NSTAGE), .DIV_W(DIV_W), .FLAG_W(FLAG_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_vld     (wr_vld),
        .wr_op      (wr_op),
        .wr_arg     (wr_arg),
        .divider    (divider),
        .read_count (read_count),
        .delay_count(delay_count),
        .flags      (flags),
        .trig_mask  (trig_mask),
        .trig_value (trig_value),
        .trig_cfg   (trig_cfg)
    );

    assign pulse_reset = stb.rst;
    assign pulse_run   = stb.run;
    assign pulse_id    = stb.id;
    assign pulse_meta  = stb.meta;
    assign demux_en    = flags[0];
    assign filter_en   = flags[1];
    assign rle_en      = flags[RLE_BIT];

    for (genvar g = 0; g < NGROUP; g++) begin : g_grp
        assign group_en[g] = ~flags[GRP_LSB + g];
    end

    for (genvar s = 0; s < NSTAGE; s++) begin : g_arm
        assign trig_arm[s] = trig_cfg[s*ARG_W + ARM_BIT];
    end

    AST_FLAGS_MATCH_GROUPS: assert property (@(posedge clk) disable iff (rst)
        (flags[GRP_LSB +: NGROUP] & group_en) == '0); // R5
endmodule

// File: tb/la_cmd_decoder_test.sv
module la_cmd_decoder_test;
    localparam int GAP = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [7:0]   in_byte = 8'h00;
    logic         in_vld = 1'b0;
    logic         pulse_reset, pulse_run, pulse_id, pulse_meta;
    logic [23:0]  divider;
    logic [16:0]  read_count, delay_count;
    logic [15:0]  flags;
    logic         demux_en, filter_en, rle_en;
    logic [3:0]   group_en, trig_arm;
    logic [127:0] trig_mask, trig_value, trig_cfg;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    la_cmd_decoder #(.GAP_CYCLES(GAP)) uut (
        .clk(clk), .rst(rst), .in_byte(in_byte), .in_vld(in_vld),
        .pulse_reset(pulse_reset), .pulse_run(pulse_run), .pulse_id(pulse_id),
        .pulse_meta(pulse_meta), .divider(divider), .read_count(read_count),
        .delay_count(delay_count), .flags(flags), .demux_en(demux_en),
        .filter_en(filter_en), .rle_en(rle_en), .group_en(group_en),
        .trig_mask(trig_mask), .trig_value(trig_value), .trig_cfg(trig_cfg),
        .trig_arm(trig_arm)
    );

    typedef struct packed {
        logic [7:0]  op;
        logic [31:0] arg;
        logic [3:0]  sel;
        logic [31:0] exp;
    } vec_t;

    // sel: 0 divider, 1 read, 2 delay, 3 flags, 4 group_en, 5 demux, 6 rle,
    //      7 filter, 8 mask of stage op[3:2], 9 value, 10 config, 11 trig_arm
    localparam vec_t VECS [14] = '{
        '{8'h80, 32'hAABBCCDD, 4'd0,  32'h00BBCCDD},
        '{8'h81, 32'h00030007, 4'd1,  32'd8},
        '{8'h81, 32'h00030007, 4'd2,  32'd4},
        '{8'h81, 32'hFFFF0000, 4'd1,  32'd1},
        '{8'h81, 32'hFFFF0000, 4'd2,  32'h10000},
        '{8'h82, 32'h00000129, 4'd3,  32'h0129},
        '{8'h82, 32'h00000129, 4'd4,  32'h5},
        '{8'h82, 32'h00000129, 4'd5,  32'h1},
        '{8'h82, 32'h00000129, 4'd6,  32'h1},
        '{8'h82, 32'h00000129, 4'd7,  32'h0},
        '{8'hC8, 32'h12345678, 4'd8,  32'h12345678},
        '{8'hCD, 32'hDEADBEEF, 4'd9,  32'hDEADBEEF},
        '{8'hC6, 32'h00000008, 4'd11, 32'h2},
        '{8'hC2, 32'h00000004, 4'd11, 32'h2}
    };

    function automatic logic [31:0] pick(input logic [3:0] sel, input logic [7:0] op);
        int s;
        s = int'(op[3:2]);
        case (sel)
            4'd0:    return 32'(divider);
            4'd1:    return 32'(read_count);
            4'd2:    return 32'(delay_count);
            4'd3:    return 32'(flags);
            4'd4:    return 32'(group_en);
            4'd5:    return 32'(demux_en);
            4'd6:    return 32'(rle_en);
            4'd7:    return 32'(filter_en);
            4'd8:    return 32'(trig_mask  >> (s*32));
            4'd9:    return 32'(trig_value >> (s*32));
            4'd10:   return 32'(trig_cfg   >> (s*32));
            default: return 32'(trig_arm);
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        in_byte = b;
        in_vld  = 1'b1;
        @(negedge clk);
        in_vld  = 1'b0;
    endtask

    task automatic send_long(input logic [7:0] op, input logic [31:0] arg);
        send_byte(op);
        for (int i = 0; i < 4; i++) send_byte(arg[i*8 +: 8]);
        @(negedge clk);
    endtask

    function automatic logic [31:0] pulses();
        return {28'd0, pulse_reset, pulse_run, pulse_id, pulse_meta};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check("R11 strobes", pulses(), 32'h0);
        check("R11 divider", 32'(divider), 32'h0);
        check("R11 read_count", 32'(read_count), 32'd1);
        check("R11 group_en", 32'(group_en), 32'hF);
        check("R11 trig_arm", 32'(trig_arm), 32'h0);

        // Table walk: R3 R4 R5 R6
        foreach (VECS[i]) begin
            send_long(VECS[i].op, VECS[i].arg);
            check($sformatf("R3-6 vector %0d", i), pick(VECS[i].sel, VECS[i].op), VECS[i].exp);
        end

        // R1 short opcodes, each one cycle wide
        send_byte(8'h00); check("R1 reset pulse", pulses(), 32'h8);
        @(negedge clk);   check("R1 pulse one cycle", pulses(), 32'h0);
        send_byte(8'h01); check("R1 run pulse", pulses(), 32'h4);
        send_byte(8'h02); check("R1 id pulse", pulses(), 32'h2);
        send_byte(8'h04); check("R1 meta pulse", pulses(), 32'h1);
        send_byte(8'h03); check("R1 unused short", pulses(), 32'h0);

        // R2 argument bytes look like short opcodes but raise nothing; byte order
        send_byte(8'h80);
        send_byte(8'h01); check("R2 arg0 no strobe", pulses(), 32'h0);
        send_byte(8'h02); check("R2 arg1 no strobe", pulses(), 32'h0);
        send_byte(8'h04); check("R2 arg2 no strobe", pulses(), 32'h0);
        // R8: three bytes in, divider still old
        check("R8 no partial write", 32'(divider), 32'h00BBCCDD);
        send_byte(8'h00); check("R2 arg3 no strobe", pulses(), 32'h0);
        check("R8 not yet one cycle", 32'(divider), 32'h00BBCCDD);
        @(negedge clk);
        check("R2 R3 byte order", 32'(divider), 32'h00040201);

        // R7 unknown long opcodes consume four bytes
        send_long(8'h83, 32'h02020202);
        check("R7 0x83 divider", 32'(divider), 32'h00040201);
        send_long(8'hC3, 32'hFFFFFFFF);
        check("R7 kind 3 mask s0", pick(4'd8, 8'hC0), 32'h0);
        check("R7 kind 3 cfg s0", pick(4'd10, 8'hC0), 32'h4);
        send_byte(8'h02); check("R7 framing kept", pulses(), 32'h2);

        // R9 five zeros after opcode and one arg
        send_byte(8'h80);
        send_byte(8'h55);
        for (int i = 0; i < 3; i++) send_byte(8'h00);
        send_byte(8'h00); check("R9 fourth zero is reset", pulses(), 32'h8);
        send_byte(8'h00); check("R9 fifth zero is reset", pulses(), 32'h8);
        check("R9 completed write", 32'(divider), 32'h00000055);
        send_byte(8'h02); check("R9 idle after zeros", pulses(), 32'h2);
        // R9 zeros right after the opcode
        send_byte(8'h82);
        for (int i = 0; i < 4; i++) send_byte(8'h00);
        send_byte(8'h00); check("R9 fifth zero after opcode", pulses(), 32'h8);
        check("R9 flags cleared by zero args", 32'(flags), 32'h0);

        // R10 gap timeout
        send_byte(8'h80);
        send_byte(8'h77);
        repeat (GAP + 8) @(negedge clk);
        send_byte(8'h02); check("R10 byte after gap is opcode", pulses(), 32'h2);
        send_byte(8'h01); check("R10 second opcode", pulses(), 32'h4);
        @(negedge clk);
        check("R10 partial dropped", 32'(divider), 32'h00000055);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule